// File: doc/BRIEF.md
# DMA Channel Request Enable Gate

This block holds one hardware request enable bit for each DMA channel (16 channels by default) and decides, on every clock, which channel service requests are passed on to the arbiter. A hardware request from a peripheral is accepted only when that channel's enable bit is set. A software-start request or a linked-channel request is accepted whatever the enable bit holds.

The host has three ways to change the enable map. It can write the whole map at once. It can set one channel through a set port, or clear one channel through a clear port; each of these takes a channel number, so the host does not have to read, modify and write the map. A flag bit in the set or clear command widens that command to every channel.

All pins are plain control and status pins, and each is sampled on every clock. No data stream flows through the block, so it has no valid/ready handshake and never applies back-pressure. A write strobe held high for one cycle is one write.

Top module: `dma_req_gate`

## Requirements
- R1: While `rst_n` is low, every enable bit clears to 0 and `acc_req` clears to 0.
- R2: A cycle with `map_wr_en` high loads `map_wr_data` into the whole enable map. Bit i of `map_wr_data` is the enable for channel i.
- R3: A cycle with `set_wr_en` high sets enable bits, and every other bit keeps its value. `set_cmd[3:0]` gives the channel number. `set_cmd[4]` = 1 sets all channels and ignores the channel number.
- R4: A cycle with `clr_wr_en` high clears enable bits, and every other bit keeps its value. `clr_cmd[3:0]` gives the channel number. `clr_cmd[4]` = 1 clears all channels.
- R5: When writes land in the same cycle, they are applied in a fixed order: the full-map write first, then the set, then the clear. A clear therefore wins over a set or a full-map write that targets the same channel.
- R6: In a cycle with no write strobe, the enable map does not change.
- R7: A hardware request `hw_req[i]` is accepted only when enable bit i is 1. The enable bit that counts is the value the map holds before the clock edge that samples the request.
- R8: `sw_req[i]` and `link_req[i]` are accepted regardless of enable bit i.
- R9: `acc_req[i]` is the OR of the gated hardware request, the software-start request and the linked request, and it is registered: it appears one clock after its inputs are sampled. A request that is not presented again drops on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| map_wr_en | input | 1 | Strobe for a full enable-map write |
| map_wr_data | input | 16 | New enable map; bit i enables channel i |
| set_wr_en | input | 1 | Strobe for a single-channel set |
| set_cmd | input | 5 | [3:0] channel number, [4] all-channels flag |
| clr_wr_en | input | 1 | Strobe for a single-channel clear |
| clr_cmd | input | 5 | [3:0] channel number, [4] all-channels flag |
| hw_req | input | 16 | Hardware service requests from peripherals |
| sw_req | input | 16 | Software-start requests |
| link_req | input | 16 | Linked-channel requests |
| en_map | output | 16 | Current enable map |
| acc_req | output | 16 | Accepted requests, registered |

## Verification
A write applied before a clock edge shows up on `en_map` directly after that edge. A request is gated by the map value from before the same edge, and its result shows up on `acc_req` directly after that edge. The bench changes inputs only at falling edges. It samples both outputs shortly after the next rising edge and compares them with a model that is advanced once per edge. For the acceptance check, the model uses the map as it stood before that edge's writes were applied.

// File: rtl/dma_req_pkg.sv
package dma_req_pkg;
  localparam int unsigned DEF_NUM_CH = 16;

  // Scope bit carried at the top of a single-channel command
  typedef enum logic {
    SCOPE_ONE = 1'b0,
    SCOPE_ALL = 1'b1
  } wr_scope_e;
endpackage

// File: rtl/dma_req_chan_decode.sv
module dma_req_chan_decode #(
  parameter int unsigned NUM_CH = 16,
  localparam int unsigned CH_W = $clog2(NUM_CH)
) (
  input  logic              cmd_en,
  input  logic [CH_W:0]     cmd,
  output logic [NUM_CH-1:0] mask
);
  import dma_req_pkg::*;

  wr_scope_e scope;
  assign scope = wr_scope_e'(cmd[CH_W]);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_bit
    assign mask[i] = cmd_en &&
                     ((scope == SCOPE_ALL) || (cmd[CH_W-1:0] == CH_W'(i)));
  end

  // a single-channel command touches at most one channel
  always_comb begin
    if (cmd_en && scope == SCOPE_ONE)
      one_hot_chk: assert ($onehot0(mask));
  end
endmodule

// File: rtl/dma_req_enable_reg.sv
module dma_req_enable_reg #(
  parameter int unsigned NUM_CH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              map_wr_en,
  input  logic [NUM_CH-1:0] map_wr_data,
  input  logic [NUM_CH-1:0] set_mask,
  input  logic [NUM_CH-1:0] clr_mask,
  output logic [NUM_CH-1:0] en_map
);
  logic [NUM_CH-1:0] after_map, after_set, nxt_map;

  // order: full write, then set, then clear
  always_comb begin
    after_map = map_wr_en ? map_wr_data : en_map;
    after_set = after_map | set_mask;
    nxt_map   = after_set & ~clr_mask;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) en_map <= '0;
    else        en_map <= nxt_map;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> en_map == '0);

  // R3
  set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_mask) && !(|(set_mask & clr_mask)) |=>
      (en_map & $past(set_mask)) == $past(set_mask));

  // R4
  clr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_mask) |=> (en_map & $past(clr_mask)) == '0);

  // R6
  map_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !map_wr_en && !(|set_mask) && !(|clr_mask) |=> $stable(en_map));
endmodule

// File: rtl/dma_req_accept.sv
module dma_req_accept #(
  parameter int unsigned NUM_CH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] en_map,
  input  logic [NUM_CH-1:0] hw_req,
  input  logic [NUM_CH-1:0] sw_req,
  input  logic [NUM_CH-1:0] link_req,
  output logic [NUM_CH-1:0] acc_req
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic gated_hw;
    assign gated_hw = hw_req[i] & en_map[i];
    always_ff @(posedge clk) begin
      if (!rst_n) acc_req[i] <= 1'b0;
      else        acc_req[i] <= gated_hw | sw_req[i] | link_req[i];
    end
  end

  // R7
  hw_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    |(hw_req & ~en_map & ~sw_req & ~link_req) |=>
      (acc_req & $past(hw_req & ~en_map & ~sw_req & ~link_req)) == '0);

  // R8
  bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    |(sw_req | link_req) |=>
      (acc_req & $past(sw_req | link_req)) == $past(sw_req | link_req));

  // R9
  idle_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(hw_req | sw_req | link_req)) |=> acc_req == '0);

  // R1
  acc_reset_chk: assert property (@(posedge clk)
    !rst_n |=> acc_req == '0);
endmodule

// File: rtl/dma_req_gate.sv
module dma_req_gate #(
  parameter int unsigned NUM_CH = dma_req_pkg::DEF_NUM_CH,
  localparam int unsigned CH_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              map_wr_en,
  input  logic [NUM_CH-1:0] map_wr_data,
  input  logic              set_wr_en,
  input  logic [CH_W:0]     set_cmd,
  input  logic              clr_wr_en,
  input  logic [CH_W:0]     clr_cmd,
  input  logic [NUM_CH-1:0] hw_req,
  input  logic [NUM_CH-1:0] sw_req,
  input  logic [NUM_CH-1:0] link_req,
  output logic [NUM_CH-1:0] en_map,
  output logic [NUM_CH-1:0] acc_req
);
  logic [NUM_CH-1:0] set_mask, clr_mask;

  dma_req_chan_decode #(.NUM_CH(NUM_CH)) u_set_dec (
    .cmd_en(set_wr_en), .cmd(set_cmd), .mask(set_mask)
  );

  dma_req_chan_decode #(.NUM_CH(NUM_CH)) u_clr_dec (
    .cmd_en(clr_wr_en), .cmd(clr_cmd), .mask(clr_mask)
  );

  dma_req_enable_reg #(.NUM_CH(NUM_CH)) u_map (
    .clk(clk), .rst_n(rst_n),
    .map_wr_en(map_wr_en), .map_wr_data(map_wr_data),
    .set_mask(set_mask), .clr_mask(clr_mask),
    .en_map(en_map)
  );

  dma_req_accept #(.NUM_CH(NUM_CH)) u_acc (
    .clk(clk), .rst_n(rst_n),
    .en_map(en_map), .hw_req(hw_req), .sw_req(sw_req), .link_req(link_req),
    .acc_req(acc_req)
  );

  // R2
  full_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    map_wr_en && !set_wr_en && !clr_wr_en |=> en_map == $past(map_wr_data));

  // R5
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr_en && clr_cmd[CH_W] |=> en_map == '0);
endmodule

// File: tb/dma_req_gate_test.sv
module dma_req_gate_test;
  localparam int unsigned N = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          map_wr_en = 1'b0;
  logic [N-1:0]  map_wr_data = '0;
  logic          set_wr_en = 1'b0;
  logic [4:0]    set_cmd = '0;
  logic          clr_wr_en = 1'b0;
  logic [4:0]    clr_cmd = '0;
  logic [N-1:0]  hw_req = '0, sw_req = '0, link_req = '0;
  logic [N-1:0]  en_map, acc_req;

  int checks = 0;
  int fails  = 0;
  logic [N-1:0] model_map = '0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dma_req_gate uut (
    .clk(clk), .rst_n(rst_n),
    .map_wr_en(map_wr_en), .map_wr_data(map_wr_data),
    .set_wr_en(set_wr_en), .set_cmd(set_cmd),
    .clr_wr_en(clr_wr_en), .clr_cmd(clr_cmd),
    .hw_req(hw_req), .sw_req(sw_req), .link_req(link_req),
    .en_map(en_map), .acc_req(acc_req)
  );

  function automatic logic [N-1:0] cmd_mask(input logic en, input logic [4:0] c);
    if (!en) return '0;
    if (c[4]) return '1;
    return N'(1) << c[3:0];
  endfunction

  function automatic logic [N-1:0] next_map(input logic [N-1:0] old);
    logic [N-1:0] m;
    m = map_wr_en ? map_wr_data : old;
    m = m | cmd_mask(set_wr_en, set_cmd);
    m = m & ~cmd_mask(clr_wr_en, clr_cmd);
    return m;
  endfunction

  function automatic logic [N-1:0] exp_acc(input logic [N-1:0] old);
    return (hw_req & old) | sw_req | link_req;
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // inputs are already driven; advance one edge and compare
  task automatic step(input string acc_tag);
    logic [N-1:0] old, em, ea;
    string mtag;
    old = model_map;
    em = next_map(old);
    ea = exp_acc(old);
    if (clr_wr_en && (set_wr_en || map_wr_en)) mtag = "R5";
    else if (set_wr_en && map_wr_en) mtag = "R5";
    else if (set_wr_en) mtag = "R3";
    else if (clr_wr_en) mtag = "R4";
    else if (map_wr_en) mtag = "R2";
    else mtag = "R6";
    @(posedge clk); #1;
    model_map = em;
    check(mtag, "en_map", en_map, em);
    check(acc_tag, "acc_req", acc_req, ea);
    @(negedge clk);
    map_wr_en = 0; set_wr_en = 0; clr_wr_en = 0;
    hw_req = '0; sw_req = '0; link_req = '0;
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1f2e3d4c));
    repeat (3) @(negedge clk);
    #1;
    check("R1", "en_map at reset", en_map, '0);
    check("R1", "acc_req at reset", acc_req, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R7 hw request with map empty is blocked
    hw_req = 16'hFFFF; step("R7");
    // R2 full write
    map_wr_en = 1; map_wr_data = 16'hA5C3; step("R9");
    // R7 gated by the map before the edge
    hw_req = 16'hFFFF; map_wr_en = 1; map_wr_data = 16'h0000; step("R7");
    // R3 single set, channel 15
    set_wr_en = 1; set_cmd = 5'h0F; step("R9");
    // R4 single clear, channel 15
    clr_wr_en = 1; clr_cmd = 5'h0F; step("R9");
    // R3 set all
    set_wr_en = 1; set_cmd = 5'h10; step("R9");
    // R4 clear all, with channel field nonzero
    clr_wr_en = 1; clr_cmd = 5'h13; step("R9");
    // R5 set and clear same channel: clear wins
    set_wr_en = 1; set_cmd = 5'h06; clr_wr_en = 1; clr_cmd = 5'h06; step("R9");
    // R5 full write then set
    map_wr_en = 1; map_wr_data = 16'h0001; set_wr_en = 1; set_cmd = 5'h08; step("R9");
    // R8 sw and link bypass an empty map
    map_wr_en = 1; map_wr_data = '0; step("R9");
    sw_req = 16'h0F00; link_req = 16'h8001; step("R8");
    // R9 request drops when not presented again
    step("R9");
    check("R6", "idle hold", en_map, model_map);

    for (int k = 0; k < 3000; k++) begin
      map_wr_en = ($urandom % 5) == 0;
      map_wr_data = N'($urandom);
      set_wr_en = ($urandom % 3) == 0;
      set_cmd = 5'($urandom % 40);
      clr_wr_en = ($urandom % 3) == 0;
      clr_cmd = 5'($urandom % 40);
      hw_req = N'($urandom);
      sw_req = N'($urandom) & N'($urandom);
      link_req = N'($urandom) & N'($urandom) & N'($urandom);
      step("R9");
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule